// File: doc/BRIEF.md
# Chainable Multi-Channel Periodic Timer

This block holds a set of down-counting channels (four by default), each producing a regular timeout from a programmable load value. Software programs it through a small single-cycle register port: a block-wide control word plus, per channel, a load value, a read-only live count, a control word and a timeout flag. Each channel drives its own interrupt request line. A debug-halt input can stop all counting when the freeze option is set.

Each active channel counts from its load value down to zero. The step after zero reloads the load value and raises the channel's timeout flag, so one period lasts load + 1 clock cycles. A channel in chained mode takes one step only in the cycle in which the channel one index below expires. This lets adjacent channels act as a single longer counter. Changing a load value never disturbs the period in progress. Turning a channel's enable off and then on again restarts the period at once from the current load value.

Top module: `cascade_timer`

## Requirements
- R1: After reset the block control word (byte address 0x000) reads 0x00000006: bit 1, module-off, is 1, bit 0, freeze, is 0, and reserved bit 2 reads as one. Every channel register reads zero and every interrupt line is low.
- R2: While module-off is 1, no channel count changes, except for the restart load of R6.
- R3: While freeze is 1 and the debug-halt input is high, no count changes. With freeze at 0, counting continues while debug-halt is high.
- R4: An enabled, unchained channel steps down by one each cycle. In the cycle it is at zero, it reloads the load value and sets its timeout flag, so the period is load + 1 cycles.
- R5: Writing a load value leaves the running count alone. The new value is used from the next reload onward.
- R6: Writing the channel control word with enable 1 while the channel is off loads the count from the load value in that cycle. A disabled channel keeps its last count.
- R7: Channel n sits at byte address 0x100 + 0x10·n, with the load value at +0x0, the live count at +0x4, control at +0x8 and flag at +0xC. Control bit 0 is enable, bit 1 is interrupt enable and bit 2 is chain. Its other bits read as zero.
- R8: A chained channel n > 0 steps, or expires and reloads, only in a cycle in which channel n−1 expires. Channel 0 stores its chain bit but always counts every cycle.
- R9: The timeout flag is bit 0 of the flag register. Writing 1 clears it, writing 0 leaves it unchanged, and an expiry in the same cycle as a clearing write leaves it set.
- R10: A channel's interrupt line is high exactly while its flag and its interrupt enable are both 1. Setting interrupt enable while the flag is already set raises the line on the following cycle.
- R11: Read data appears one cycle after a read strobe and is zero in every cycle that follows no read. Unmapped or unaligned addresses read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dbg_halt_i | input | 1 | Debug-halt indication, honoured when freeze is set |
| sel_i | input | 1 | Register access strobe |
| wr_i | input | 1 | 1 = write, 0 = read, when sel_i is high |
| addr_i | input | 9 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | NCH | Per-channel interrupt request |

## Verification
Directed sequences first program a channel with module-off set, then release it. They check that the channel holds its count and afterwards expires. A load rewrite in mid-period shows the old period finishing untouched, while a disable and re-enable shows an immediate restart. A pair of chained channels, with chain also set on channel 0, distinguishes event-driven stepping from per-clock stepping and confirms that channel 0 ignores its chain bit. Freeze is tried with debug-halt both high and low. A long run of seeded random register traffic then mixes short loads, chain and interrupt-enable toggles, stray clears, unmapped accesses and debug pulses, comparing every read and every interrupt line against a cycle-level model; it catches collisions such as a clear landing on an expiry.

// File: rtl/cascade_timer_pkg.sv
`timescale 1ns/1ps
package cascade_timer_pkg;
   // Register port geometry
   localparam int unsigned ADDR_W     = 9;
   localparam int unsigned IDX_W      = 4;   // channel index field addr[7:4]
   localparam int unsigned MAX_CH     = 16;

   // Block control word bit positions
   localparam int unsigned MC_FREEZE  = 0;
   localparam int unsigned MC_OFF     = 1;

   // Channel control word bit positions
   localparam int unsigned CC_EN      = 0;
   localparam int unsigned CC_IE      = 1;
   localparam int unsigned CC_CHAIN   = 2;
   localparam int unsigned CC_W       = 3;

   // Flag register bit position
   localparam int unsigned FL_TIMEOUT = 0;

   // Register slot inside a channel window (addr[3:2])
   typedef enum logic [1:0] {
      SLOT_LOAD = 2'd0,
      SLOT_CUR  = 2'd1,
      SLOT_CTL  = 2'd2,
      SLOT_FLAG = 2'd3
   } slot_e;

   typedef struct packed {
      logic             mctl;
      logic             chan;
      logic [IDX_W-1:0] idx;
      slot_e            slot;
   } hit_t;

   typedef struct packed {
      logic chain;
      logic ie;
      logic en;
   } chctl_t;
endpackage

// File: rtl/ct_addr_dec.sv
`timescale 1ns/1ps
module ct_addr_dec
   import cascade_timer_pkg::*;
#(
   parameter int unsigned NCH = 4
) (
   input  logic [ADDR_W-1:0] addr_i,
   output hit_t              hit_o
);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NCH - 1);

   logic aligned;
   logic in_window;
   logic idx_ok;

   assign aligned   = (addr_i[1:0] == 2'b00);
   assign in_window = addr_i[8];
   assign idx_ok    = (addr_i[7:4] <= LAST_IDX);

   always_comb begin
      hit_o      = '0;
      hit_o.idx  = addr_i[7:4];
      hit_o.slot = slot_e'(addr_i[3:2]);
      hit_o.mctl = (addr_i == '0);
      hit_o.chan = in_window & aligned & idx_ok;
   end
endmodule

// File: rtl/ct_channel.sv
`timescale 1ns/1ps
module ct_channel
   import cascade_timer_pkg::*;
#(
   parameter int unsigned CNT_W     = 32,
   parameter int unsigned DATA_W    = 32,
   parameter bit          CAN_CHAIN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_i,
   input  logic              prev_expire_i,
   input  logic              wr_load_i,
   input  logic              wr_ctl_i,
   input  logic              wr_flag_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [CNT_W-1:0]  load_o,
   output logic [CNT_W-1:0]  cur_o,
   output chctl_t            ctl_o,
   output logic              flag_o,
   output logic              expire_o,
   output logic              irq_o
);
   localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   logic [CNT_W-1:0] load_q;
   logic [CNT_W-1:0] cur_q;
   chctl_t           ctl_q;
   logic             flag_q;
   logic             tick;
   logic             step;
   logic             at_zero;
   logic             restart;
   logic             clr_req;

   // Step source: every clock, or the lower neighbour's expiry
   generate
      if (CAN_CHAIN) begin : g_chainable
         assign tick = ctl_q.chain ? prev_expire_i : 1'b1;
      end else begin : g_free_running
         assign tick = 1'b1 | prev_expire_i;
      end
   endgenerate

   assign step     = ctl_q.en & run_i & tick;
   assign at_zero  = (cur_q == '0);
   assign expire_o = step & at_zero;
   assign restart  = wr_ctl_i & wdata_i[CC_EN] & ~ctl_q.en;
   assign clr_req  = wr_flag_i & wdata_i[FL_TIMEOUT];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         load_q <= '0;
      end else if (wr_load_i) begin
         load_q <= wdata_i[CNT_W-1:0];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_q <= '0;
      end else if (restart) begin
         cur_q <= load_q;
      end else if (step) begin
         cur_q <= at_zero ? load_q : (cur_q - ONE);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl_q <= '0;
      end else if (wr_ctl_i) begin
         ctl_q <= chctl_t'(wdata_i[CC_W-1:0]);
      end
   end

   // Expiry outranks a same-cycle clear
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
      end else if (expire_o) begin
         flag_q <= 1'b1;
      end else if (clr_req) begin
         flag_q <= 1'b0;
      end
   end

   assign load_o = load_q;
   assign cur_o  = cur_q;
   assign ctl_o  = ctl_q;
   assign flag_o = flag_q;
   assign irq_o  = flag_q & ctl_q.ie;
endmodule

// File: rtl/cascade_timer.sv
`timescale 1ns/1ps
module cascade_timer
   import cascade_timer_pkg::*;
#(
   parameter int unsigned NCH    = 4,
   parameter int unsigned CNT_W  = 32,
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dbg_halt_i,
   input  logic              sel_i,
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic [NCH-1:0]    irq_o
);
   // Elaboration-time parameter checks
   generate
      if (NCH < 1 || NCH > MAX_CH) begin : g_bad_nch
         $error("cascade_timer: NCH must be within 1..16");
      end
      if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt
         $error("cascade_timer: CNT_W must be within 2..DATA_W");
      end
      if (DATA_W < 8) begin : g_bad_data
         $error("cascade_timer: DATA_W must be at least 8");
      end
   endgenerate

   hit_t hit;
   logic wr_en;
   logic rd_en;
   logic freeze_q;
   logic off_q;
   logic run;

   logic [NCH-1:0][CNT_W-1:0] load_v;
   logic [NCH-1:0][CNT_W-1:0] cur_v;
   chctl_t [NCH-1:0]          ctl_v;
   logic [NCH-1:0]            flag_v;
   logic [NCH-1:0]            expire_v;
   logic [NCH-1:0]            prev_v;
   logic [NCH-1:0]            wr_load_v;
   logic [NCH-1:0]            wr_ctl_v;
   logic [NCH-1:0]            wr_flag_v;
   logic [DATA_W-1:0]         rd_next;
   logic [DATA_W-1:0]         mctl_word;

   ct_addr_dec #(.NCH(NCH)) u_dec (
      .addr_i (addr_i),
      .hit_o  (hit)
   );

   assign wr_en = sel_i & wr_i;
   assign rd_en = sel_i & ~wr_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         freeze_q <= 1'b0;
         off_q    <= 1'b1;
      end else if (wr_en && hit.mctl) begin
         freeze_q <= wdata_i[MC_FREEZE];
         off_q    <= wdata_i[MC_OFF];
      end
   end

   assign run = ~off_q & ~(freeze_q & dbg_halt_i);

   always_comb begin
      mctl_word            = '0;
      mctl_word[MC_FREEZE] = freeze_q;
      mctl_word[MC_OFF]    = off_q;
      mctl_word[2]         = 1'b1;
   end

   generate
      for (genvar n = 0; n < NCH; n++) begin : g_ch
         localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(n);
         logic here;

         assign here         = wr_en & hit.chan & (hit.idx == MY_IDX);
         assign wr_load_v[n] = here & (hit.slot == SLOT_LOAD);
         assign wr_ctl_v[n]  = here & (hit.slot == SLOT_CTL);
         assign wr_flag_v[n] = here & (hit.slot == SLOT_FLAG);

         if (n == 0) begin : g_head
            assign prev_v[n] = 1'b0;
         end else begin : g_link
            assign prev_v[n] = expire_v[n-1];
         end

         ct_channel #(
            .CNT_W     (CNT_W),
            .DATA_W    (DATA_W),
            .CAN_CHAIN (n != 0)
         ) u_ch (
            .clk           (clk),
            .rst_n         (rst_n),
            .run_i         (run),
            .prev_expire_i (prev_v[n]),
            .wr_load_i     (wr_load_v[n]),
            .wr_ctl_i      (wr_ctl_v[n]),
            .wr_flag_i     (wr_flag_v[n]),
            .wdata_i       (wdata_i),
            .load_o        (load_v[n]),
            .cur_o         (cur_v[n]),
            .ctl_o         (ctl_v[n]),
            .flag_o        (flag_v[n]),
            .expire_o      (expire_v[n]),
            .irq_o         (irq_o[n])
         );
      end
   endgenerate

   // Read mux: one-hot over channels, zero when nothing matches
   always_comb begin
      rd_next = '0;
      if (rd_en) begin
         if (hit.mctl) begin
            rd_next = mctl_word;
         end else if (hit.chan) begin
            for (int n = 0; n < NCH; n++) begin
               if (hit.idx == IDX_W'(n)) begin
                  unique case (hit.slot)
                     SLOT_LOAD: rd_next = DATA_W'(load_v[n]);
                     SLOT_CUR:  rd_next = DATA_W'(cur_v[n]);
                     SLOT_CTL:  rd_next = DATA_W'(ctl_v[n]);
                     SLOT_FLAG: rd_next = DATA_W'(flag_v[n]);
                  endcase
               end
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata_o <= '0;
      end else begin
         rdata_o <= rd_next;
      end
   end
endmodule

// File: rtl/cascade_timer_chk.sv
`timescale 1ns/1ps
module cascade_timer_chk
   import cascade_timer_pkg::*;
#(
   parameter int unsigned NCH    = 4,
   parameter int unsigned CNT_W  = 32,
   parameter int unsigned DATA_W = 32
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      dbg_halt_i,
   input logic                      sel_i,
   input logic                      wr_i,
   input logic [ADDR_W-1:0]         addr_i,
   input logic [DATA_W-1:0]         wdata_i,
   input logic [DATA_W-1:0]         rdata_o,
   input logic                      freeze_q,
   input logic                      off_q,
   input logic [NCH-1:0][CNT_W-1:0] load_v,
   input logic [NCH-1:0][CNT_W-1:0] cur_v,
   input chctl_t [NCH-1:0]          ctl_v,
   input logic [NCH-1:0]            flag_v,
   input logic [NCH-1:0]            expire_v
);
   logic mapped;
   assign mapped = (addr_i == '0) ||
                   (addr_i[8] && addr_i[1:0] == 2'b00 && (32'(addr_i[7:4]) < NCH));

   // R11: reads of holes return zero
   a_r11_hole_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_i && !wr_i && !mapped) |=> (rdata_o == '0));

   // R11: no read strobe, no data
   a_r11_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !(sel_i && !wr_i) |=> (rdata_o == '0));

   generate
      for (genvar n = 0; n < NCH; n++) begin : g_c
         localparam logic [ADDR_W-1:0] FLAG_ADDR = ADDR_W'(32'h10C + 32'h10 * n);
         logic clr_hit;
         assign clr_hit = sel_i & wr_i & (addr_i == FLAG_ADDR) & wdata_i[FL_TIMEOUT];

         a_r2_off_holds: assert property (@(posedge clk) disable iff (!rst_n)
            (off_q && ctl_v[n].en) |=> $stable(cur_v[n]));

         a_r3_freeze_holds: assert property (@(posedge clk) disable iff (!rst_n)
            (freeze_q && dbg_halt_i && ctl_v[n].en) |=> $stable(cur_v[n]));

         a_r4_expiry_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
            expire_v[n] |=> flag_v[n]);

         a_r4_expiry_reloads: assert property (@(posedge clk) disable iff (!rst_n)
            expire_v[n] |=> (cur_v[n] == $past(load_v[n])));

         a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_v[n] && !clr_hit) |=> flag_v[n]);

         if (n > 0) begin : g_chain
            a_r8_chain_waits: assert property (@(posedge clk) disable iff (!rst_n)
               (ctl_v[n].en && ctl_v[n].chain && !expire_v[n-1]) |=> $stable(cur_v[n]));
         end
      end
   endgenerate
endmodule

bind cascade_timer cascade_timer_chk #(
   .NCH    (NCH),
   .CNT_W  (CNT_W),
   .DATA_W (DATA_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .dbg_halt_i (dbg_halt_i),
   .sel_i      (sel_i),
   .wr_i       (wr_i),
   .addr_i     (addr_i),
   .wdata_i    (wdata_i),
   .rdata_o    (rdata_o),
   .freeze_q   (freeze_q),
   .off_q      (off_q),
   .load_v     (load_v),
   .cur_v      (cur_v),
   .ctl_v      (ctl_v),
   .flag_v     (flag_v),
   .expire_v   (expire_v)
);

// File: tb/cascade_timer_tb.sv
`timescale 1ns/1ps
module cascade_timer_tb;
   localparam int NCH = 4;
   localparam real HALF = 4.0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        dbg = 1'b0;
   logic        sel = 1'b0;
   logic        wr = 1'b0;
   logic [8:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [NCH-1:0] irq;

   int  n_checks = 0;
   int  n_fails  = 0;
   bit  chk_on   = 1'b0;
   bit  done     = 1'b0;
   string phase  = "R1";

   always #(HALF) clk = ~clk;

   cascade_timer #(.NCH(NCH), .CNT_W(32), .DATA_W(32)) u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .dbg_halt_i (dbg),
      .sel_i      (sel),
      .wr_i       (wr),
      .addr_i     (addr),
      .wdata_i    (wdata),
      .rdata_o    (rdata),
      .irq_o      (irq)
   );

   // Reference model state
   bit          m_frz, m_off;
   logic [31:0] m_ld [NCH];
   logic [31:0] m_cur[NCH];
   bit          m_en [NCH];
   bit          m_ie [NCH];
   bit          m_chn[NCH];
   bit          m_flag[NCH];
   logic [31:0] m_rd;

   function automatic logic [31:0] model_read(input logic [8:0] a);
      logic [31:0] v;
      int c;
      v = '0;
      c = int'(a[7:4]);
      if (a == 9'h000) v = {29'd0, 1'b1, m_off, m_frz};
      else if (a[8] && a[1:0] == 2'b00 && c < NCH) begin
         case (a[3:2])
            2'd0: v = m_ld[c];
            2'd1: v = m_cur[c];
            2'd2: v = {29'd0, m_chn[c], m_ie[c], m_en[c]};
            default: v = {31'd0, m_flag[c]};
         endcase
      end
      return v;
   endfunction

   function automatic logic [3:0] model_irq();
      logic [3:0] r;
      for (int c = 0; c < NCH; c++) r[c] = m_flag[c] & m_ie[c];
      return r;
   endfunction

   always @(posedge clk) begin
      bit run;
      bit ex [NCH];
      bit stp[NCH];
      if (!rst_n) begin
         m_frz = 1'b0; m_off = 1'b1; m_rd = '0;
         for (int c = 0; c < NCH; c++) begin
            m_ld[c] = '0; m_cur[c] = '0; m_en[c] = 1'b0;
            m_ie[c] = 1'b0; m_chn[c] = 1'b0; m_flag[c] = 1'b0;
         end
      end else begin
         run = !m_off && !(m_frz && dbg);
         for (int c = 0; c < NCH; c++) begin
            bit tk;
            tk = 1'b1;
            if (c > 0 && m_chn[c]) tk = ex[c-1];
            stp[c] = m_en[c] && run && tk;
            ex[c]  = stp[c] && (m_cur[c] == 0);
         end
         m_rd = (sel && !wr) ? model_read(addr) : '0;
         for (int c = 0; c < NCH; c++) begin
            logic [8:0] base;
            base = 9'(9'h100 + 16 * c);
            if (sel && wr && addr == base + 9'h8 && wdata[0] && !m_en[c])
               m_cur[c] = m_ld[c];
            else if (stp[c])
               m_cur[c] = ex[c] ? m_ld[c] : m_cur[c] - 1;
            if (ex[c]) m_flag[c] = 1'b1;
            else if (sel && wr && addr == base + 9'hC && wdata[0]) m_flag[c] = 1'b0;
            if (sel && wr && addr == base) m_ld[c] = wdata;
            if (sel && wr && addr == base + 9'h8) begin
               m_en[c] = wdata[0]; m_ie[c] = wdata[1]; m_chn[c] = wdata[2];
            end
         end
         if (sel && wr && addr == 9'h000) begin
            m_frz = wdata[0]; m_off = wdata[1];
         end
      end
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", tag, act, exp, $time);
      end
   endtask

   // Continuous comparison against the model, away from the active edge
   always @(negedge clk) begin
      if (chk_on && rst_n) begin
         check({phase, " rdata"}, rdata, m_rd);
         check({phase, " irq"}, 32'(irq), 32'(model_irq()));
      end
   end

   task automatic wr_reg(input logic [8:0] a, input logic [31:0] d);
      sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      sel = 1'b0; wr = 1'b0;
   endtask

   task automatic rd_get(input logic [8:0] a, output logic [31:0] v);
      sel = 1'b1; wr = 1'b0; addr = a;
      @(negedge clk);
      v = rdata;
      sel = 1'b0;
   endtask

   task automatic rd_exp(input logic [8:0] a, input logic [31:0] exp, input string tag);
      logic [31:0] v;
      rd_get(a, v);
      check(tag, v, exp);
   endtask

   task automatic idle(input int k);
      repeat (k) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fails++;
         $display("FAIL watchdog (all requirements): actual hung expected finished");
         $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] v1, v2;
      void'($urandom(32'd20240611));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      chk_on = 1'b1;

      // R1 reset values
      phase = "R1";
      check("R1 irq at reset", 32'(irq), 32'd0);
      rd_exp(9'h000, 32'h6, "R1 block control");
      rd_exp(9'h100, 32'h0, "R1 load");
      rd_exp(9'h104, 32'h0, "R1 count");
      rd_exp(9'h108, 32'h0, "R1 control");
      rd_exp(9'h13C, 32'h0, "R1 flag ch3");

      // R7 control layout, reserved bits read zero
      phase = "R7";
      wr_reg(9'h118, 32'hFFFF_FFFE);
      rd_exp(9'h118, 32'h6, "R7 control reserved bits");
      wr_reg(9'h118, 32'h0);
      wr_reg(9'h120, 32'hDEAD_BEEF);
      rd_exp(9'h120, 32'hDEAD_BEEF, "R7 ch2 load address");

      // R11 holes
      phase = "R11";
      wr_reg(9'h004, 32'hFFFF_FFFF);
      wr_reg(9'h102, 32'hFFFF_FFFF);
      rd_exp(9'h004, 32'h0, "R11 hole read");
      rd_exp(9'h140, 32'h0, "R11 missing channel read");
      rd_exp(9'h102, 32'h0, "R11 unaligned read");
      rd_exp(9'h000, 32'h6, "R11 hole write ignored");
      rd_exp(9'h100, 32'h0, "R11 unaligned write ignored");
      idle(1);
      check("R11 idle rdata", rdata, 32'h0);

      // R2 module off holds the count
      phase = "R2";
      wr_reg(9'h100, 32'd3);
      wr_reg(9'h108, 32'h1);
      idle(5);
      rd_exp(9'h104, 32'd3, "R2 count held while off");
      rd_exp(9'h10C, 32'd0, "R2 no expiry while off");

      // R4 counting and expiry
      phase = "R4";
      wr_reg(9'h000, 32'h0);
      idle(20);
      rd_exp(9'h10C, 32'd1, "R4 flag after expiry");

      // R9 write-one-to-clear
      phase = "R9";
      wr_reg(9'h108, 32'h0);
      wr_reg(9'h10C, 32'h0);
      rd_exp(9'h10C, 32'd1, "R9 write zero ignored");
      wr_reg(9'h10C, 32'h1);
      rd_exp(9'h10C, 32'd0, "R9 write one clears");

      // R10 interrupt on late enable
      phase = "R10";
      wr_reg(9'h108, 32'h1);
      idle(10);
      wr_reg(9'h108, 32'h0);
      check("R10 no irq without enable", 32'(irq[0]), 32'd0);
      wr_reg(9'h108, 32'h2);
      check("R10 irq on enable with pending flag", 32'(irq[0]), 32'd1);
      wr_reg(9'h10C, 32'h1);
      check("R10 irq drops with flag", 32'(irq[0]), 32'd0);

      // R6 restart, R5 deferred load
      phase = "R6";
      wr_reg(9'h100, 32'd7);
      wr_reg(9'h108, 32'h1);
      rd_exp(9'h104, 32'd7, "R6 restart loads count");
      phase = "R5";
      wr_reg(9'h100, 32'd2);
      rd_exp(9'h104, 32'd5, "R5 running count undisturbed");
      idle(12);
      phase = "R6";
      wr_reg(9'h108, 32'h0);
      rd_get(9'h104, v1);
      idle(6);
      rd_exp(9'h104, v1, "R6 disabled count held");

      // R8 chaining
      phase = "R8";
      wr_reg(9'h10C, 32'h1);
      wr_reg(9'h100, 32'd2);
      wr_reg(9'h110, 32'd1);
      wr_reg(9'h118, 32'h5);
      wr_reg(9'h108, 32'h5);
      idle(2);
      rd_exp(9'h114, 32'd1, "R8 chained channel waits");
      idle(20);
      rd_exp(9'h11C, 32'd1, "R8 chained channel expired");
      rd_exp(9'h108, 32'h5, "R8 channel 0 keeps chain bit");
      wr_reg(9'h128, 32'h7);
      wr_reg(9'h120, 32'd3);
      idle(60);

      // R3 freeze with debug
      phase = "R3";
      wr_reg(9'h000, 32'h1);
      dbg = 1'b1;
      rd_get(9'h104, v1);
      idle(5);
      rd_get(9'h104, v2);
      check("R3 frozen in debug", v2, v1);
      dbg = 1'b0;
      idle(5);
      wr_reg(9'h000, 32'h0);
      dbg = 1'b1;
      idle(15);
      dbg = 1'b0;

      // Random traffic against the model
      phase = "R4 R5 R8 R9 R10 random";
      for (int i = 0; i < 2500; i++) begin
         int pick, ch, slot, gap;
         logic [8:0] a;
         logic [31:0] d;
         pick = int'($urandom % 10);
         ch   = int'($urandom % NCH);
         slot = int'($urandom % 4);
         if (pick == 0) begin
            a = 9'h000;
            d = ($urandom % 8 == 0) ? ($urandom & 32'h3) : 32'h0;
         end else if (pick == 9) begin
            case ($urandom % 4)
               0: a = 9'h004;
               1: a = 9'h180;
               2: a = 9'h1FC;
               default: a = 9'h10E;
            endcase
            d = $urandom;
         end else begin
            a = 9'(9'h100 + 16 * ch + 4 * slot);
            case (slot)
               0: d = $urandom % 24;
               2: d = $urandom % 8;
               3: d = $urandom % 2;
               default: d = $urandom;
            endcase
         end
         dbg = ($urandom % 4 == 0);
         sel = 1'b1; wr = ($urandom % 2 == 0); addr = a; wdata = d;
         @(negedge clk);
         sel = 1'b0; wr = 1'b0;
         gap = int'($urandom % 4);
         idle(gap);
      end
      dbg = 1'b0;
      idle(2);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
   end
endmodule